// File: doc/BRIEF.md
# Bus Grant Handler

This block decides when the processor gives its address, data and control buses to an external DMA master, and when it takes them back. It watches an active-low request line from that master. It also watches a strobe from the processor's cycle sequencer that marks the final clock of each machine cycle. The request counts only on an edge where that strobe is high. At all other times the request line is ignored.

Once a request is accepted, the handler holds the sequencer so that no new machine cycle starts. One clock later it turns off every bus output enable and asserts the active-low acknowledge. Interrupt recognition is masked from acceptance until the buses are driven again. The master may keep the buses for as long as it wants. When the handler sees the request line high during the grant, it drives the buses again on the next edge and releases the sequencer. The handler moves no data and does no memory refresh.

Top module: `busgrant_ctrl`

## Requirements
- R1: After reset the handler is idle: `grant_ack_n`=1, every bit of `bus_drive_en`=1, `irq_hold`=0, `seq_stall`=0.
- R2: While idle, a low `dma_req_n` on an edge where `mcyc_end`=0 has no effect: all outputs keep their idle values after that edge.
- R3: While idle, an edge with `mcyc_end`=1 and `dma_req_n`=0 accepts the request. After that edge `seq_stall`=1, while `grant_ack_n` stays 1 and the buses stay driven.
- R4: On the edge after acceptance, `grant_ack_n` goes to 0 and every bit of `bus_drive_en` goes to 0 on that same edge.
- R5: While granted, every edge with `dma_req_n`=0 keeps the grant, whatever `mcyc_end` does. There is no limit on the number of cycles.
- R6: While granted, an edge with `dma_req_n`=1 ends the grant. After that edge `grant_ack_n`=1, all of `bus_drive_en`=1, `seq_stall`=0 and `irq_hold`=0.
- R7: `irq_hold` is 1 from the edge that accepts a request until the edge that ends the grant, and 0 at all other times.
- R8: An accepted request always leads to a grant, even if `dma_req_n` returns high during the pending clock. The grant then lasts one clock and ends at the following edge.
- R9: All bits of `bus_drive_en` always carry the same value.
- R10: While idle, an edge with `mcyc_end`=1 and `dma_req_n`=1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_req_n | input | 1 | Bus request from the external master, active low |
| mcyc_end | input | 1 | High during the final clock of a machine cycle |
| grant_ack_n | output | 1 | Bus acknowledge, active low |
| bus_drive_en | output | NUM_GROUPS | Output enable per bus group (1 = processor drives) |
| irq_hold | output | 1 | Masks NMI and INT recognition while high |
| seq_stall | output | 1 | Holds the cycle sequencer before its next machine cycle |

## Verification
The bench builds the block with `NUM_GROUPS`=5 rather than the default of 3. This shows that the generated enable vector stays uniform across a width other than the default (R9). A behavioural reference model is compared with the outputs on every clock. It covers three kinds of stimulus: directed accept and release, a request dropped during the pending clock, and a grant held for several hundred cycles. A long pseudo-random stretch of request and end-of-cycle patterns then reaches every ordering of these events.

// File: rtl/bg_pkg.sv
package bg_pkg;
    typedef enum logic [1:0] {
        BG_RUN   = 2'd0,
        BG_PEND  = 2'd1,
        BG_GRANT = 2'd2
    } bg_state_e;

    typedef struct packed {
        bg_state_e state;
    } bg_regs_t;
endpackage

// File: rtl/bg_sample.sv
module bg_sample (
    input  logic dma_req_n,
    input  logic mcyc_end,
    output logic take,
    output logic give_back
);
    always_comb begin
        take      = mcyc_end & ~dma_req_n;
        give_back = dma_req_n;
    end
endmodule

// File: rtl/bg_fsm.sv
module bg_fsm
    import bg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      take,
    input  logic      give_back,
    output bg_state_e state
);
    bg_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        case (regs_q.state)
            BG_RUN:   if (take)      regs_d.state = BG_PEND;
            BG_PEND:                 regs_d.state = BG_GRANT;
            BG_GRANT: if (give_back) regs_d.state = BG_RUN;
            default:                 regs_d.state = BG_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{state: BG_RUN};
        else        regs_q <= regs_d;
    end

    assign state = regs_q.state;
endmodule

// File: rtl/bg_drive.sv
module bg_drive
    import bg_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 3
) (
    input  bg_state_e             state,
    output logic                  grant_ack_n,
    output logic [NUM_GROUPS-1:0] bus_drive_en,
    output logic                  irq_hold,
    output logic                  seq_stall
);
    logic floating;

    always_comb begin
        floating    = (state == BG_GRANT);
        grant_ack_n = ~floating;
        seq_stall   = (state != BG_RUN);
        irq_hold    = (state != BG_RUN);
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign bus_drive_en[g] = ~floating;
    end
endmodule

// File: rtl/busgrant_ctrl.sv
module busgrant_ctrl
    import bg_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dma_req_n,
    input  logic                  mcyc_end,
    output logic                  grant_ack_n,
    output logic [NUM_GROUPS-1:0] bus_drive_en,
    output logic                  irq_hold,
    output logic                  seq_stall
);
    logic      take;
    logic      give_back;
    bg_state_e state;

    bg_sample u_sample (
        .dma_req_n (dma_req_n),
        .mcyc_end  (mcyc_end),
        .take      (take),
        .give_back (give_back)
    );

    bg_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .give_back (give_back),
        .state     (state)
    );

    bg_drive #(.NUM_GROUPS(NUM_GROUPS)) u_drive (
        .state        (state),
        .grant_ack_n  (grant_ack_n),
        .bus_drive_en (bus_drive_en),
        .irq_hold     (irq_hold),
        .seq_stall    (seq_stall)
    );
endmodule

// File: rtl/bg_checker.sv
module bg_checker #(
    parameter int unsigned NUM_GROUPS = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  dma_req_n,
    input logic                  mcyc_end,
    input logic                  grant_ack_n,
    input logic [NUM_GROUPS-1:0] bus_drive_en,
    input logic                  irq_hold,
    input logic                  seq_stall
);
    assert_idle_ignores_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_stall && !mcyc_end) |=> (!seq_stall && grant_ack_n));

    assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_stall && mcyc_end && !dma_req_n) |=> (seq_stall && grant_ack_n && (&bus_drive_en)));

    assert_float_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_stall && grant_ack_n) |=> (!grant_ack_n && (bus_drive_en == '0)));

    assert_hold_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_ack_n && !dma_req_n) |=> !grant_ack_n);

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_ack_n && dma_req_n) |=> (grant_ack_n && (&bus_drive_en) && !seq_stall && !irq_hold));

    assert_mask_span_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hold == seq_stall);

    assert_uniform_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_drive_en == '0) || (&bus_drive_en)));

    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_stall && dma_req_n) |=> !seq_stall);
endmodule

bind busgrant_ctrl bg_checker #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dma_req_n    (dma_req_n),
    .mcyc_end     (mcyc_end),
    .grant_ack_n  (grant_ack_n),
    .bus_drive_en (bus_drive_en),
    .irq_hold     (irq_hold),
    .seq_stall    (seq_stall)
);

// File: tb/sim_busgrant_ctrl.sv
`timescale 1ns/1ps
module sim_busgrant_ctrl;
    localparam int NG = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dma_req_n = 1'b1;
    logic mcyc_end = 1'b0;
    logic grant_ack_n;
    logic [NG-1:0] bus_drive_en;
    logic irq_hold;
    logic seq_stall;

    int total = 0;
    int bad = 0;
    int mst = 0;           // model: 0 idle, 1 pending, 2 granted
    string cur_req = "R1";
    bit finished = 0;

    always #10 clk = ~clk;

    busgrant_ctrl #(.NUM_GROUPS(NG)) u0 (
        .clk(clk), .rst_n(rst_n), .dma_req_n(dma_req_n), .mcyc_end(mcyc_end),
        .grant_ack_n(grant_ack_n), .bus_drive_en(bus_drive_en),
        .irq_hold(irq_hold), .seq_stall(seq_stall)
    );

    // Behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) mst = 0;
        else begin
            case (mst)
                0: if (mcyc_end && !dma_req_n) mst = 1;
                1: mst = 2;
                default: if (dma_req_n) mst = 0;
            endcase
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(cur_req, "grant_ack_n", int'(grant_ack_n), (mst == 2) ? 0 : 1);
            chk(cur_req, "bus_drive_en", int'(bus_drive_en), (mst == 2) ? 0 : (1 << NG) - 1);
            chk(cur_req, "seq_stall", int'(seq_stall), (mst != 0) ? 1 : 0);
            chk("R7", "irq_hold", int'(irq_hold), (mst != 0) ? 1 : 0);
            chk("R9", "uniform enables", int'((bus_drive_en == '0) || (&bus_drive_en)), 1);
        end
    end

    task automatic step(logic rq, logic me);
        @(negedge clk);
        dma_req_n = rq;
        mcyc_end  = me;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lfsr = 32'h1ACE5;
        repeat (2) @(negedge clk);
        chk("R1", "reset grant_ack_n", int'(grant_ack_n), 1);
        chk("R1", "reset bus_drive_en", int'(bus_drive_en), (1 << NG) - 1);
        chk("R1", "reset irq_hold", int'(irq_hold), 0);
        chk("R1", "reset seq_stall", int'(seq_stall), 0);
        rst_n = 1'b1;
        repeat (3) step(1'b1, 1'b0);

        cur_req = "R2";
        repeat (6) step(1'b0, 1'b0);
        cur_req = "R10";
        repeat (3) step(1'b1, 1'b1);

        cur_req = "R3";
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        cur_req = "R4";
        step(1'b0, 1'b1);
        cur_req = "R5";
        for (int i = 0; i < 12; i++) step(1'b0, i[0]);
        cur_req = "R6";
        step(1'b1, 1'b0);
        repeat (3) step(1'b1, 1'b0);

        cur_req = "R8";
        step(1'b0, 1'b1);
        step(1'b1, 1'b0);
        repeat (4) step(1'b1, 1'b0);

        cur_req = "R5";
        step(1'b0, 1'b1);
        repeat (300) step(1'b0, 1'b0);
        cur_req = "R6";
        step(1'b1, 1'b1);
        repeat (2) step(1'b1, 1'b0);

        cur_req = "R9";
        for (int i = 0; i < 3000; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
            step(lfsr[3:1] == 3'b000, lfsr[7:5] == 3'b000);
        end

        @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule